// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block collects interrupt flags from a group of peripheral modules and presents one request line to a processor core. The core has only one interrupt entry address. Every source therefore lands at the same handler, and that handler reads the identification register to find out which module wants service.

The block keeps three pieces of state:
- **Identification register.** It has one bit per module and copies that module's flag line. Software cannot write it. A bit drops only when the module clears its own flag.
- **Mask register.** It has one bit per module and is loaded by software. It only decides whether a pending flag may raise the request.
- **In-service bit.** Hardware sets it when the core takes the vector. While it is set, every further request is blocked. A return strobe clears it. Software may also clear it from inside a handler, which lets unmasked sources nest.

A global enable input gates the request as well.

Top module: `sv_intc`

## Requirements
- R1: Identification bit n equals the value module flag n had at the previous rising clock edge. This holds whatever the mask bit n is. No input other than the flag line changes it.
- R2: When the mask write strobe is 1 at a rising edge, the mask register holds the written data after that edge. Otherwise the mask register keeps its value.
- R3: The request output is 1 exactly when all three of these hold in the same cycle, with no register stage in between:
  - the in-service bit is 0;
  - the global enable input is 1;
  - at least one module has both its identification bit and its mask bit at 1.
- R4: The vector-taken output is 1 exactly when the acknowledge input and the request output are both 1. At that edge the in-service bit becomes 1.
- R5: A return strobe at a rising edge clears the in-service bit, unless the vector is taken in the same cycle.
- R6: A software write to the in-service bit loads the written value at the edge. Priority, from highest to lowest:
  1. A taken vector sets the bit and overrides a software write of 0.
  2. A return strobe clears the bit and overrides a software write of 1.
  3. A software write loads its value.
- R7: An acknowledge while the request output is 0 has no effect. The in-service bit stays unchanged.
- R8: While reset is asserted, and right after it, all of the following hold:
  - the identification register is all zeros;
  - the mask register is all zeros;
  - the in-service bit is 0;
  - the request output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_i | input | NUM_SRC | Per-module pending interrupt flags |
| glb_en_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Core acknowledge: branching to the vector |
| ret_i | input | 1 | Core return-from-interrupt strobe |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wd_i | input | NUM_SRC | Mask write data |
| ins_we_i | input | 1 | In-service bit write strobe |
| ins_wd_i | input | 1 | In-service write data |
| irq_o | output | 1 | Interrupt request to the core |
| vec_taken_o | output | 1 | Vector taken in this cycle |
| id_o | output | NUM_SRC | Identification register read value |
| mask_o | output | NUM_SRC | Mask register read value |
| ins_o | output | 1 | In-service bit read value |

## Verification
The request and vector-taken outputs are combinational from current state and inputs. The bench checks them in the same cycle, after the inputs settle and before the rising edge.

The identification, mask and in-service values are each one register stage from their causes. The bench samples them one edge after the stimulus, away from the active edge.

Every expected value comes from the bench's own model of the mask and in-service state, which it carries from one table row to the next. Rows are ordered so that ties between acknowledge, return and software writes occur in a known state.

// File: rtl/sv_intc_pkg.sv
package sv_intc_pkg;

  // Request qualification: nothing while in service, nothing when disabled.
  function automatic logic req_eval(input logic any_unmasked,
                                    input logic in_svc,
                                    input logic en);
    return any_unmasked & en & ~in_svc;
  endfunction

  // In-service next state; priority: taken vector, return, software write.
  function automatic logic ins_next(input logic cur,
                                    input logic taken,
                                    input logic ret,
                                    input logic we,
                                    input logic wd);
    logic n;
    if (taken)      n = 1'b1;
    else if (ret)   n = 1'b0;
    else if (we)    n = wd;
    else            n = cur;
    return n;
  endfunction

endpackage

// File: rtl/intc_id_capture.sv
module intc_id_capture #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  output logic [NUM_SRC-1:0] id_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) id_q[g] <= 1'b0;
      else        id_q[g] <= flag_i[g];
    end
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wd,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= wd;
  end
endmodule

// File: rtl/intc_ins_ctrl.sv
module intc_ins_ctrl
  import sv_intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic taken,
  input  logic ret,
  input  logic we,
  input  logic wd,
  output logic ins_q
);
  logic ins_d;
  always_comb ins_d = ins_next(ins_q, taken, ret, we, wd);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins_q <= 1'b0;
    else        ins_q <= ins_d;
  end
endmodule

// File: rtl/sv_intc.sv
module sv_intc
  import sv_intc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic               glb_en_i,
  input  logic               ack_i,
  input  logic               ret_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wd_i,
  input  logic               ins_we_i,
  input  logic               ins_wd_i,
  output logic               irq_o,
  output logic               vec_taken_o,
  output logic [NUM_SRC-1:0] id_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               ins_o
);
  logic [NUM_SRC-1:0] id_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] unmasked;
  logic               any_unmasked;
  logic               ins_q;
  logic               req;
  logic               taken;

  intc_id_capture #(.NUM_SRC(NUM_SRC)) u_id (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .id_q(id_q)
  );

  intc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we_i), .wd(mask_wd_i), .mask_q(mask_q)
  );

  always_comb begin
    unmasked     = id_q & mask_q;
    any_unmasked = |unmasked;
    req          = req_eval(any_unmasked, ins_q, glb_en_i);
    taken        = req & ack_i;
  end

  intc_ins_ctrl u_ins (
    .clk(clk), .rst_n(rst_n), .taken(taken), .ret(ret_i),
    .we(ins_we_i), .wd(ins_wd_i), .ins_q(ins_q)
  );

  assign irq_o       = req;
  assign vec_taken_o = taken;
  assign id_o        = id_q;
  assign mask_o      = mask_q;
  assign ins_o       = ins_q;
endmodule

// File: rtl/sv_intc_chk.sv
module sv_intc_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] flag_i,
  input logic               glb_en_i,
  input logic               ack_i,
  input logic               ret_i,
  input logic               mask_we_i,
  input logic [NUM_SRC-1:0] mask_wd_i,
  input logic               ins_we_i,
  input logic               ins_wd_i,
  input logic               irq_o,
  input logic               vec_taken_o,
  input logic [NUM_SRC-1:0] id_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic               ins_o
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_ID_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> id_o == $past(flag_i)); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(mask_we_i)) |-> mask_o == $past(mask_wd_i)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(mask_we_i)) |-> $stable(mask_o)); // R2
  AST_NO_REQ_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_o |-> !irq_o); // R3
  AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (glb_en_i && (|(id_o & mask_o)))); // R3
  AST_TAKE_SETS_INS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken_o |=> ins_o); // R4
  AST_TAKE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken_o |-> (ack_i && irq_o)); // R4
  AST_RET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !vec_taken_o) |=> !ins_o); // R5
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !ret_i && !ins_we_i) |=> ins_o == $past(ins_o)); // R7
endmodule

bind sv_intc sv_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/sv_intc_tb.sv
module sv_intc_tb;
  localparam int N = 8;
  localparam int NV = 18;

  typedef struct packed {
    logic [7:0] flag;
    logic       en;
    logic       ack;
    logic       ret;
    logic       mwe;
    logic [7:0] mwd;
    logic       iwe;
    logic       iwd;
    logic       x_irq;
    logic       x_take;
    logic       x_ins;
  } vec_t;

  //  flag   en ack ret mwe mwd   iwe iwd  irq take ins
  localparam vec_t TBL [NV] = '{
    '{8'h01, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0}, // id fills
    '{8'h01, 1'b1,1'b0,1'b0,1'b1,8'h03,1'b0,1'b0, 1'b0,1'b0,1'b0}, // mask write
    '{8'h01, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b0,1'b0}, // request
    '{8'h01, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0}, // disabled
    '{8'h01, 1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b1,1'b1}, // take
    '{8'h03, 1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1}, // blocked
    '{8'h03, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b0}, // sw clear
    '{8'h03, 1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // take beats sw 0
    '{8'h00, 1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0}, // return
    '{8'h80, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0},
    '{8'h80, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0}, // masked, id set
    '{8'h80, 1'b1,1'b0,1'b0,1'b1,8'h80,1'b0,1'b0, 1'b0,1'b0,1'b0},
    '{8'h80, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b0,1'b0},
    '{8'h80, 1'b1,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b1,1'b1}, // take beats ret
    '{8'h00, 1'b1,1'b0,1'b1,1'b0,8'h00,1'b1,1'b1, 1'b0,1'b0,1'b0}, // ret beats sw 1
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0}, // idle ack R7
    '{8'h00, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b1, 1'b0,1'b0,1'b1}, // sw set
    '{8'h00, 1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] flag_i = '0;
  logic         glb_en_i = 1'b0;
  logic         ack_i = 1'b0;
  logic         ret_i = 1'b0;
  logic         mask_we_i = 1'b0;
  logic [N-1:0] mask_wd_i = '0;
  logic         ins_we_i = 1'b0;
  logic         ins_wd_i = 1'b0;
  logic         irq_o;
  logic         vec_taken_o;
  logic [N-1:0] id_o;
  logic [N-1:0] mask_o;
  logic         ins_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] m_mask;

  always #5 clk = ~clk;

  sv_intc #(.NUM_SRC(N)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    flag_i = v.flag; glb_en_i = v.en; ack_i = v.ack; ret_i = v.ret;
    mask_we_i = v.mwe; mask_wd_i = v.mwd; ins_we_i = v.iwe; ins_wd_i = v.iwd;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 id in reset", id_o, 0);
    chk("R8 mask in reset", mask_o, 0);
    chk("R8 ins in reset", ins_o, 0);
    chk("R8 irq in reset", irq_o, 0);
    rst_n = 1'b1;
    m_mask = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1;
      chk($sformatf("R3 irq row %0d", i), irq_o, TBL[i].x_irq);
      chk($sformatf("R4 take row %0d", i), vec_taken_o, TBL[i].x_take);
      if (TBL[i].mwe) m_mask = TBL[i].mwd;
      @(posedge clk);
      #2;
      chk($sformatf("R1 id row %0d", i), id_o, TBL[i].flag);
      chk($sformatf("R2 mask row %0d", i), mask_o, m_mask);
      chk($sformatf("R4 R5 R6 R7 ins row %0d", i), ins_o, TBL[i].x_ins);
    end
    // Mid-operation reset: build state, then reset.
    @(negedge clk);
    drive('{8'hFF, 1'b1,1'b0,1'b0,1'b1,8'hFF,1'b0,1'b0, 1'b0,1'b0,1'b0});
    @(negedge clk);
    drive('{8'hFF, 1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0});
    #1;
    chk("R4 take before reset", vec_taken_o, 1);
    @(negedge clk);
    drive('{8'hFF, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0});
    chk("R4 ins before reset", ins_o, 1);
    rst_n = 1'b0;
    #1;
    chk("R8 id after reset", id_o, 0);
    chk("R8 mask after reset", mask_o, 0);
    chk("R8 ins after reset", ins_o, 0);
    chk("R8 irq after reset", irq_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 id tracks flag while mask is zero", id_o, 8'hFF);
    chk("R3 no request with mask zero", irq_o, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule